// File: doc/BRIEF.md
# Sticky Event Status and Vectored Interrupt Controller

This block gathers two kinds of per-channel events, overflow and index, from a set of counting channels. Each event sets a bit in a status register, and the bit stays set until software clears it. A separate mask register for each group decides which latched bits may raise that group's interrupt line. Overflow events drive one request line and index events drive the other. A mask bit blocks only the interrupt. The status bit still records the event.

Software reaches every register through a small read/write port with an address, a write strobe and a combinational read path. It can also read the current up/down direction of every channel. When the host acknowledges an interrupt, the block returns an 8-bit vector. The upper seven bits come from a programmable register. The low bit is set by hardware from the request being acknowledged.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An overflow event on a channel sets that channel's bit in the overflow status register (address 0), and an index event sets its bit in the index status register (address 1). A set bit stays set until it is cleared.
- R2: A write of any data to address 0 clears every overflow status bit. A write of any data to address 1 clears every index status bit.
- R3: An event that arrives in the same cycle as a clear write to its status register wins: that channel's bit is set after the write.
- R4: A channel whose mask bit is 1 still latches its status bit but does not assert its group's interrupt line. The overflow mask is at address 3 and the index mask is at address 4.
- R5: `irq_ovf` is high exactly when some overflow status bit is set with its mask bit 0. `irq_idx` follows the same rule for the index group. Each line falls in the cycle after its status register is cleared.
- R6: A write to address 5 stores data bits 7 to 1 as the vector base. Reading address 5 returns the stored base with bit 0 equal to 0.
- R7: While `iack` is high, `iack_vec` equals the vector base in bits 7 to 1 and `iack_sel` in bit 0. With base 0xAA it reads 0xAA for the overflow request (`iack_sel`=0) and 0xAB for the index request (`iack_sel`=1). While `iack` is low, `iack_vec` is 0.
- R8: Reading address 2 returns the current `dir_up` inputs, one bit per channel, where 1 means counting up.
- R9: After reset, both status registers are 0, both masks are all ones (every channel masked), the vector base is 0, and both interrupt lines are low.
- R10: Reads of addresses 6 and 7 return 0. Read data bits above the channel count are 0, and writes to those mask bits are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_evt | input | NCH | Per-channel overflow event pulses |
| idx_evt | input | NCH | Per-channel index event pulses |
| dir_up | input | NCH | Per-channel count direction, 1 = up |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at reg_addr |
| irq_ovf | output | 1 | Interrupt request 0, overflow group |
| irq_idx | output | 1 | Interrupt request 1, index group |
| iack | input | 1 | Interrupt acknowledge strobe |
| iack_sel | input | 1 | Request being acknowledged, 0 = overflow, 1 = index |
| iack_vec | output | 8 | Vector returned during acknowledge |

## Verification
The assertions assume that event inputs and register writes change only between clock edges. They also assume each event is a level that is sampled once per cycle, so an event held for several cycles just re-sets an already set bit. The bench drives every input on the falling edge and returns events and write strobes to zero before the next rising edge, except in the cycles that deliberately overlap an event with a clear. The acknowledge check is combinational, so the bench changes `iack` and `iack_sel` only while no write is pending.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NCH = 6,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ovf_evt,
  input  logic [NCH-1:0] idx_evt,
  input  logic [NCH-1:0] dir_up,
  input  logic [2:0]     reg_addr,
  input  logic           reg_wr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq_ovf,
  output logic           irq_idx,
  input  logic           iack,
  input  logic           iack_sel,
  output logic [DW-1:0]  iack_vec
);
  localparam logic [2:0] A_OSTAT = 3'd0;
  localparam logic [2:0] A_ISTAT = 3'd1;
  localparam logic [2:0] A_DIR   = 3'd2;
  localparam logic [2:0] A_OMASK = 3'd3;
  localparam logic [2:0] A_IMASK = 3'd4;
  localparam logic [2:0] A_VEC   = 3'd5;

  logic [NCH-1:0] ostat, istat, omask, imask;
  logic [DW-1:1]  vbase;

  wire wr_ostat = reg_wr && reg_addr == A_OSTAT;
  wire wr_istat = reg_wr && reg_addr == A_ISTAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ostat <= '0;
      istat <= '0;
      omask <= '1;
      imask <= '1;
      vbase <= '0;
    end else begin
      ostat <= (wr_ostat ? '0 : ostat) | ovf_evt;
      istat <= (wr_istat ? '0 : istat) | idx_evt;
      if (reg_wr && reg_addr == A_OMASK) omask <= reg_wdata[NCH-1:0];
      if (reg_wr && reg_addr == A_IMASK) imask <= reg_wdata[NCH-1:0];
      if (reg_wr && reg_addr == A_VEC)   vbase <= reg_wdata[DW-1:1];
    end
  end

  assign irq_ovf  = |(ostat & ~omask);
  assign irq_idx  = |(istat & ~imask);
  assign iack_vec = iack ? {vbase, iack_sel} : '0;

  always_comb begin
    case (reg_addr)
      A_OSTAT: reg_rdata = DW'(ostat);
      A_ISTAT: reg_rdata = DW'(istat);
      A_DIR:   reg_rdata = DW'(dir_up);
      A_OMASK: reg_rdata = DW'(omask);
      A_IMASK: reg_rdata = DW'(imask);
      A_VEC:   reg_rdata = {vbase, 1'b0};
      default: reg_rdata = '0;
    endcase
  end

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ostat |=> ((ostat & $past(ostat)) == $past(ostat)));

  p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|idx_evt) |=> ((istat & $past(idx_evt)) == $past(idx_evt)));

  p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_OMASK && reg_wdata[NCH-1:0] == {NCH{1'b1}}) |=> !irq_ovf);

  p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istat && idx_evt == '0) |=> !irq_idx);

  p_vec_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_VEC) |=> (vbase == $past(reg_wdata[DW-1:1])));
endmodule

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;
  localparam int NCH = 6;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ovf_evt = '0, idx_evt = '0, dir_up = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, iack = 0, iack_sel = 0;
  logic [7:0] reg_wdata = '0, reg_rdata, iack_vec;
  logic irq_ovf, irq_idx;
  int checks = 0, errors = 0;

  evt_irq_ctrl #(.NCH(NCH)) dut (.*);

  always #5 clk = ~clk;

  // ovf, idx, wr, waddr, wdata, raddr, exp rdata, exp {irq_ovf,irq_idx}
  localparam logic [36:0] TBL [0:11] = '{
    {6'h05, 6'h00, 1'b0, 3'd0, 8'h00, 3'd0, 8'h05, 2'b00}, // R1 R4 latched while masked
    {6'h00, 6'h00, 1'b1, 3'd3, 8'h00, 3'd0, 8'h05, 2'b10}, // R5 unmask overflow
    {6'h00, 6'h21, 1'b0, 3'd0, 8'h00, 3'd1, 8'h21, 2'b10}, // R1 R4 index masked
    {6'h00, 6'h00, 1'b1, 3'd4, 8'h1E, 3'd4, 8'h1E, 2'b11}, // R5 partial index mask
    {6'h02, 6'h00, 1'b0, 3'd0, 8'h00, 3'd0, 8'h07, 2'b11}, // R1 sticky accumulate
    {6'h00, 6'h00, 1'b1, 3'd0, 8'h77, 3'd0, 8'h00, 2'b01}, // R2 R5 clear overflow
    {6'h00, 6'h08, 1'b1, 3'd1, 8'h00, 3'd1, 8'h08, 2'b00}, // R3 event beats clear
    {6'h00, 6'h00, 1'b1, 3'd5, 8'h55, 3'd5, 8'h54, 2'b00}, // R6 bit 0 not stored
    {6'h00, 6'h00, 1'b0, 3'd0, 8'h00, 3'd6, 8'h00, 2'b00}, // R10 unused address
    {6'h00, 6'h00, 1'b1, 3'd4, 8'h00, 3'd1, 8'h08, 2'b01}, // R4 unmask index
    {6'h10, 6'h00, 1'b1, 3'd0, 8'h00, 3'd0, 8'h10, 2'b11}, // R3 overflow beats clear
    {6'h00, 6'h00, 1'b1, 3'd3, 8'hFF, 3'd3, 8'h3F, 2'b01}  // R4 R10 upper mask bits
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R9 irq at reset", {6'b0, irq_ovf, irq_idx}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(3'd0, 8'h00, "R9 ovf status");
    rd(3'd1, 8'h00, "R9 idx status");
    rd(3'd3, 8'h3F, "R9 ovf mask");
    rd(3'd4, 8'h3F, "R9 idx mask");
    rd(3'd5, 8'h00, "R9 vector");
    chk("R9 irq after reset", {6'b0, irq_ovf, irq_idx}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {ovf_evt, idx_evt, reg_wr, reg_addr, reg_wdata} = TBL[i][36:13];
      @(negedge clk);
      ovf_evt = '0; idx_evt = '0; reg_wr = 0;
      reg_addr = TBL[i][12:10];
      #1;
      chk($sformatf("R1-table row %0d rdata", i), reg_rdata, TBL[i][9:2]);
      chk($sformatf("R5 row %0d irq", i), {6'b0, irq_ovf, irq_idx}, {6'b0, TBL[i][1:0]});
    end

    dir_up = 6'h2A;
    rd(3'd2, 8'h2A, "R8 direction");
    dir_up = 6'h15;
    rd(3'd2, 8'h15, "R8 direction change");
    rd(3'd7, 8'h00, "R10 address 7");

    @(negedge clk); reg_wr = 1; reg_addr = 3'd5; reg_wdata = 8'hAA;
    @(negedge clk); reg_wr = 0;
    iack = 1; iack_sel = 0; #1;
    chk("R7 ack request 0", iack_vec, 8'hAA);
    iack_sel = 1; #1;
    chk("R7 ack request 1", iack_vec, 8'hAB);
    iack = 0; #1;
    chk("R7 idle vector", iack_vec, 8'h00);

    @(negedge clk); reg_wr = 1; reg_addr = 3'd1;
    @(negedge clk); reg_wr = 0; #1;
    chk("R2 R5 index clear drops irq", {6'b0, irq_ovf, irq_idx}, 8'h00);
    rd(3'd0, 8'h10, "R2 index clear leaves overflow");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule